// File: doc/BRIEF.md
# Three-Wire Serial Byte EEPROM Model

This block is a synthesizable behavioural model of a small serial EEPROM with 128 bytes. A host talks to it over a select line (active high), a serial clock and a serial data input. The model answers on a serial data output. The three host pins are not synchronous to the system clock. They are passed through a synchronizer, and the model acts on edges of the synchronized serial clock.

Each command frame is ten bits long: a start bit, a two-bit opcode and a seven-bit address. A program command may be followed by a data byte. The supported commands are:

- reading a byte;
- programming a byte;
- erasing a byte;
- setting and clearing a write-enable latch;
- erasing the whole array;
- filling the whole array with one byte.

Program and erase commands take effect when the select line falls. They then hold the model busy for a fixed number of system clocks. While select is high again, the data output shows whether the model is still busy or is ready.

The pins are plain levels with no valid/ready pairing. The serial clock paces every transfer. The model applies no back-pressure except the busy state, during which it ignores new frames.

Top module: `uw_eeprom`

## Requirements
- R1: After reset the data output is low, every byte reads 0xFF, the write-enable latch is clear, and the data output is low whenever select is low.
- R2: While select is high, 0 bits clocked in before the first 1 bit are skipped. The first 1 bit is the start bit. The next nine bits are the opcode (first two bits) and then the address, MSB first.
- R3: Opcode 10 is a read. After the rising clock edge that carries the last address bit, the output shows a dummy 0. Each later rising edge then presents the next bit of the addressed byte, MSB first.
- R4: Opcode 01 is a write. It is followed by eight data bits, MSB first, and it stores that byte at the address when select falls.
- R5: Program and erase commands change no byte while the latch is clear. Opcode 00 with address bits [6:5] = 11 sets the latch; with bits [6:5] = 00 it clears the latch.
- R6: Opcode 11 sets the addressed byte to 0xFF and leaves other bytes unchanged.
- R7: Opcode 00 with address bits [6:5] = 10 sets every byte to 0xFF.
- R8: Opcode 00 with address bits [6:5] = 01 is followed by a data byte. That byte is copied into every location.
- R9: A program or erase that takes effect holds the model busy for BUSY_CYCLES system clocks. While select is high after such an operation, the output is low while busy and high once ready.
- R10: Frames started while busy are ignored and change no memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high (asynchronous) |
| sk_i | input | 1 | Serial clock from the host (asynchronous) |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data or busy/ready status to the host |

## Verification
The hardest case to reach is a complete, well-formed write frame that arrives while a previous program cycle is still running. The bench handles it with a busy time longer than one frame. It drops select right after one write and at once sends a second write to another address. It then waits for ready and reads both locations: the first must hold the new byte, the second its old value. Status polling is checked the same way, with a sample shortly after select rises and another after the busy window has ended.

// File: rtl/uw_eeprom_pkg.sv
package uw_eeprom_pkg;
  localparam int UW_AW = 7;
  localparam int UW_DW = 8;
  localparam int UW_HDR_BITS = 2 + UW_AW;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_ERASE,
    OP_ERASE_ALL,
    OP_FILL_ALL
  } op_e;

  typedef struct packed {
    op_e              kind;
    logic [UW_AW-1:0] addr;
    logic [UW_DW-1:0] data;
  } op_t;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_HDR,
    FR_READ,
    FR_WDATA,
    FR_DONE
  } frame_st_e;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/uw_frame.sv
module uw_frame
  import uw_eeprom_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_q,
  input  logic             sk_rise,
  input  logic             di_q,
  input  logic             busy,
  input  logic [UW_DW-1:0] peek_byte,
  output logic [UW_AW-1:0] peek_addr,
  output op_t              pend,
  output logic             pend_vld,
  output logic             wel_set,
  output logic             wel_clr,
  output logic             start_p,
  output logic             rd_active,
  output logic             rd_bit
);
  localparam int CW = $clog2(UW_HDR_BITS + 1);

  frame_st_e        st;
  logic [CW-1:0]    cnt;
  logic [UW_HDR_BITS-2:0] sh;
  logic [UW_DW-1:0] rbuf;
  logic [UW_DW-1:0] dat;
  logic [1:0]       opc;
  logic [UW_AW-1:0] hdr_addr;

  assign opc       = sh[UW_HDR_BITS-2 -: 2];
  assign hdr_addr  = {sh[UW_AW-2:0], di_q};
  assign peek_addr = hdr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FR_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rbuf      <= '0;
      dat       <= '0;
      pend      <= '{kind: OP_NONE, addr: '0, data: '0};
      pend_vld  <= 1'b0;
      wel_set   <= 1'b0;
      wel_clr   <= 1'b0;
      start_p   <= 1'b0;
      rd_active <= 1'b0;
      rd_bit    <= 1'b0;
    end else begin
      wel_set <= 1'b0;
      wel_clr <= 1'b0;
      start_p <= 1'b0;
      if (!cs_q) begin
        st        <= FR_IDLE;
        pend_vld  <= 1'b0;
        rd_active <= 1'b0;
        rd_bit    <= 1'b0;
      end else if (sk_rise) begin
        unique case (st)
          FR_IDLE: begin
            if (di_q && !busy) begin
              st      <= FR_HDR;
              cnt     <= '0;
              start_p <= 1'b1;
            end
          end
          FR_HDR: begin
            sh  <= {sh[UW_HDR_BITS-3:0], di_q};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(UW_HDR_BITS - 1)) begin
              pend.addr <= hdr_addr;
              unique case (opc)
                2'b10: begin
                  rbuf      <= peek_byte;
                  rd_active <= 1'b1;
                  rd_bit    <= 1'b0;
                  st        <= FR_READ;
                end
                2'b01: begin
                  pend.kind <= OP_WRITE;
                  cnt       <= '0;
                  st        <= FR_WDATA;
                end
                2'b11: begin
                  pend.kind <= OP_ERASE;
                  pend_vld  <= 1'b1;
                  st        <= FR_DONE;
                end
                default: begin
                  unique case (hdr_addr[UW_AW-1 -: 2])
                    2'b11: begin wel_set <= 1'b1; st <= FR_DONE; end
                    2'b00: begin wel_clr <= 1'b1; st <= FR_DONE; end
                    2'b10: begin
                      pend.kind <= OP_ERASE_ALL;
                      pend_vld  <= 1'b1;
                      st        <= FR_DONE;
                    end
                    default: begin
                      pend.kind <= OP_FILL_ALL;
                      cnt       <= '0;
                      st        <= FR_WDATA;
                    end
                  endcase
                end
              endcase
            end
          end
          FR_READ: begin
            rd_bit <= rbuf[UW_DW-1];
            rbuf   <= {rbuf[UW_DW-2:0], 1'b0};
          end
          FR_WDATA: begin
            dat <= {dat[UW_DW-2:0], di_q};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(UW_DW - 1)) begin
              pend.data <= {dat[UW_DW-2:0], di_q};
              pend_vld  <= 1'b1;
              st        <= FR_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uw_store.sv
module uw_store
  import uw_eeprom_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wel_set,
  input  logic             wel_clr,
  input  logic             fire,
  input  op_t              op,
  input  logic [UW_AW-1:0] peek_addr,
  output logic [UW_DW-1:0] peek_byte,
  output logic             wel
);
  localparam int DEPTH = 1 << UW_AW;

  logic [UW_DW-1:0] mem [DEPTH];

  assign peek_byte = mem[peek_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else if (wel_set) wel <= 1'b1;
    else if (wel_clr) wel <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (fire) begin
      unique case (op.kind)
        OP_WRITE:     mem[op.addr] <= op.data;
        OP_ERASE:     mem[op.addr] <= '1;
        OP_ERASE_ALL: for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        OP_FILL_ALL:  for (int i = 0; i < DEPTH; i++) mem[i] <= op.data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uw_busy.sv
module uw_busy #(
  parameter int CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int BW = $clog2(CYCLES + 1);

  logic [BW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left <= '0;
    else if (start) left <= BW'(CYCLES);
    else if (left != '0) left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom
  import uw_eeprom_pkg::*;
#(
  parameter int BUSY_CYCLES = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  logic [2:0]       pins_q;
  logic             cs_q, sk_q, di_q;
  logic             cs_prev, sk_prev;
  logic             sk_rise, cs_fall;
  logic [UW_AW-1:0] peek_addr;
  logic [UW_DW-1:0] peek_byte;
  op_t              pend;
  logic             pend_vld, wel_set, wel_clr, start_p;
  logic             rd_active, rd_bit;
  logic             wel, busy, fire, status_q, do_q;

  uw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({cs_i, sk_i, di_i}), .q(pins_q)
  );
  assign {cs_q, sk_q, di_q} = pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev <= 1'b0;
      sk_prev <= 1'b0;
    end else begin
      cs_prev <= cs_q;
      sk_prev <= sk_q;
    end
  end
  assign sk_rise = sk_q & ~sk_prev;
  assign cs_fall = ~cs_q & cs_prev;

  uw_frame frame_i (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .sk_rise(sk_rise), .di_q(di_q),
    .busy(busy), .peek_byte(peek_byte), .peek_addr(peek_addr), .pend(pend),
    .pend_vld(pend_vld), .wel_set(wel_set), .wel_clr(wel_clr),
    .start_p(start_p), .rd_active(rd_active), .rd_bit(rd_bit)
  );

  assign fire = cs_fall & pend_vld & wel & ~busy;

  uw_store store_i (
    .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
    .fire(fire), .op(pend), .peek_addr(peek_addr), .peek_byte(peek_byte),
    .wel(wel)
  );

  uw_busy #(.CYCLES(BUSY_CYCLES)) busy_i (
    .clk(clk), .rst_n(rst_n), .start(fire), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      do_q     <= 1'b0;
    end else begin
      if (fire) status_q <= 1'b1;
      else if (start_p) status_q <= 1'b0;
      do_q <= cs_q & (status_q ? ~busy : (rd_active & rd_bit));
    end
  end
  assign do_o = do_q;
endmodule

// File: rtl/uw_eeprom_chk.sv
module uw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_q,
  input logic do_o,
  input logic busy,
  input logic wel,
  input logic fire,
  input logic status_q
);
  p_deselect_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> !do_o);
  p_gate_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> wel);
  p_fire_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy);
  p_busy_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy);
  p_status_busy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && status_q && busy) |=> !do_o);
  p_status_ready_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && status_q && !busy) |=> do_o);
endmodule

bind uw_eeprom uw_eeprom_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .do_o(do_o), .busy(busy),
  .wel(wel), .fire(fire), .status_q(status_q)
);

// File: tb/uw_eeprom_tb_top.sv
module uw_eeprom_tb_top;
  localparam int BUSY = 300;
  localparam int PH   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_w;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] mir [128];

  always #5 clk = ~clk;

  uw_eeprom #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(do_w)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    di = b; tick(PH); sk = 1'b1; tick(PH); sk = 1'b0;
  endtask

  task automatic header(input logic [1:0] opc, input logic [6:0] a, input int zeros);
    cs = 1'b1; tick(PH);
    for (int i = 0; i < zeros; i++) bit_out(1'b0);
    bit_out(1'b1);
    bit_out(opc[1]); bit_out(opc[0]);
    for (int i = 6; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic byte_out(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
  endtask

  task automatic deselect();
    di = 1'b0; cs = 1'b0; tick(PH);
  endtask

  task automatic wait_ready(input string req);
    cs = 1'b1; tick(8);
    check(req, {7'd0, do_w}, 8'h00);
    tick(BUSY + 40);
    check(req, {7'd0, do_w}, 8'h01);
    deselect();
  endtask

  task automatic rd(input logic [6:0] a, input string req);
    logic [7:0] got;
    header(2'b10, a, 0);
    tick(PH);
    check({req, " dummy"}, {7'd0, do_w}, 8'h00);
    for (int i = 7; i >= 0; i--) begin
      sk = 1'b1; tick(PH); sk = 1'b0; tick(PH);
      got[i] = do_w;
    end
    deselect();
    check(req, got, mir[a]);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mir[i] = 8'hFF;
    tick(4); rst_n = 1'b1; tick(4);
    // R1: reset values
    check("R1 do", {7'd0, do_w}, 8'h00);
    rd(7'd0, "R1");
    rd(7'd127, "R1");
    // R5: write with latch clear has no effect
    header(2'b01, 7'd5, 0); byte_out(8'h3C); deselect(); tick(20);
    check("R5 no busy", {7'd0, do_w}, 8'h00);
    rd(7'd5, "R5");
    // R2: enable latch with leading zeros
    header(2'b00, 7'b1100000, 3); deselect();
    // R4 sweep with R9 status on every write
    for (int a = 0; a < 128; a++) begin
      logic [7:0] v;
      v = 8'((a * 37 + 5) & 255);
      header(2'b01, 7'(a), (a % 3 == 0) ? 2 : 0); byte_out(v); deselect();
      mir[a] = v;
      wait_ready("R9");
    end
    for (int a = 0; a < 128; a++) rd(7'(a), "R4 R3 R2");
    // R6 erase single byte
    header(2'b11, 7'd10, 0); deselect(); mir[10] = 8'hFF; wait_ready("R9");
    rd(7'd10, "R6"); rd(7'd11, "R6 neighbour");
    // R10 frame while busy
    header(2'b01, 7'd20, 0); byte_out(8'h5A); deselect(); mir[20] = 8'h5A;
    header(2'b01, 7'd21, 0); byte_out(8'h00); deselect();
    tick(BUSY + 40);
    rd(7'd21, "R10"); rd(7'd20, "R10 first");
    // R5 disable latch then write
    header(2'b00, 7'b0000000, 0); deselect();
    header(2'b01, 7'd30, 0); byte_out(8'h11); deselect(); tick(20);
    rd(7'd30, "R5 disabled");
    header(2'b11, 7'd31, 0); deselect(); tick(20);
    rd(7'd31, "R5 erase blocked");
    header(2'b00, 7'b1100000, 0); deselect();
    // R8 fill all
    header(2'b00, 7'b0100000, 0); byte_out(8'hA5); deselect();
    for (int i = 0; i < 128; i++) mir[i] = 8'hA5;
    wait_ready("R9");
    for (int a = 0; a < 128; a += 9) rd(7'(a), "R8");
    rd(7'd127, "R8");
    // R7 erase all
    header(2'b00, 7'b1000000, 0); deselect();
    for (int i = 0; i < 128; i++) mir[i] = 8'hFF;
    wait_ready("R9");
    for (int a = 0; a < 128; a += 5) rd(7'(a), "R7");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule